// File: doc/BRIEF.md
# Multi-Output Interrupt Aggregator

This block collects fourteen external interrupt lines and ten internal request bits. It drives three interrupt output pins that do not depend on one another. Each external line first passes through a two-flop synchronizer. A per-line polarity bit and a per-line trigger-type bit then qualify it as rising-edge, falling-edge, active-high or active-low. The internal requests come from two timer ticks, four DMA channels, one watchdog and three bus-error sources. They arrive already in the clock domain as single-bit requests.

Each output pin owns a source mask and a status copy. An output is high while any source that is both pending in its status copy and enabled in its mask is set. No encoding or priority is applied, so several outputs may be high at the same time. A plain register port handles configuration, raw-pin readback, masking and write-one-to-clear of pending bits. Writes take effect on the clock edge. Reads are combinational, with no handshake. The block has no data stream, so no valid/ready interface appears.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the polarity, trigger-type and mask registers read zero and every output pin is low. The synchronizers reset to the idle-high level, so lines held high show no status.
- R2: Trigger-type bit 0 selects level mode and polarity selects the active level: 0 means active-low, 1 means active-high. In level mode, status bit i (i = 0..13) follows the synchronized line.
- R3: In edge mode, polarity 1 latches a sticky pending bit on a rising change and polarity 0 latches it on a falling change. The change is measured on the synchronized value between two consecutive clocks, so a pin change shows in status on the third rising clock edge and not on the second.
- R4: Writing 1 to a status bit of an edge-mode line clears that bit. Writing 0 leaves it unchanged, and a pending bit stays set until it is cleared.
- R5: A clear write to a level-mode line has no effect while its level is still active.
- R6: Internal request j sets sticky status bit 14+j in every status copy. Bits 14-15 are timers, 16-19 are DMA, 20 is the watchdog and 21-23 are bus errors. If a request is still high during a clear, the bit stays set.
- R7: Output k is high exactly when status copy k ANDed with mask k is non-zero. Each copy is cleared only through its own address.
- R8: Reading a status copy returns the pending bits whether or not they are masked.
- R9: The raw-pin register (address 2) returns the synchronized, unqualified state of lines 13..0.
- R10: The register addresses are: 0 polarity, 1 trigger type, 2 raw pins, 4+k mask k, 8+k status k. Unused addresses and bits above bit 23 (above bit 13 for address 0..2) read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_in | input | 14 | External interrupt lines, asynchronous |
| int_req | input | 10 | Internal request bits, synchronous |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_out | output | 3 | Interrupt output pins |

## Verification
Two situations are hard to reach from the ports. The first is a clear write that lands while a source is still requesting. The bench reaches it by holding an internal request high across the write, and by holding a level-mode line active across a clear, then reading the status back. The second is the exact synchronizer latency. The bench changes a pin on a falling clock edge and samples status after the second and third rising edges. Independence of the outputs is shown by routing one line to output 1 but not output 0, then clearing only copy 1.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int ADDR_W    = 4;
  localparam int DATA_W    = 32;
  localparam int MASK_BASE = 4;
  localparam int STAT_BASE = 8;

  typedef enum logic [ADDR_W-1:0] {
    ADR_POL  = 4'd0,
    ADR_TRIG = 4'd1,
    ADR_RAW  = 4'd2
  } cfg_addr_e;
endpackage

// File: rtl/irq_line_cond.sv
module irq_line_cond #(
  parameter int N_LINES     = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] pin_in,
  input  logic [N_LINES-1:0] pol,
  output logic [N_LINES-1:0] raw,
  output logic [N_LINES-1:0] evt,
  output logic [N_LINES-1:0] lvl
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [N_LINES-1:0] stg [SYNC_STAGES];
  logic [N_LINES-1:0] prev;

  // idle-high reset so no spurious edge appears when released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) stg[s] <= '1;
      prev <= '1;
    end else begin
      stg[0] <= pin_in;
      for (int s = 1; s < SYNC_STAGES; s++) stg[s] <= stg[s-1];
      prev <= stg[LAST];
    end
  end

  genvar i;
  generate
    for (i = 0; i < N_LINES; i++) begin : g_line
      logic rise, fall;
      assign rise   = stg[LAST][i] & ~prev[i];
      assign fall   = ~stg[LAST][i] & prev[i];
      assign evt[i] = pol[i] ? rise : fall;
      assign lvl[i] = ~(stg[LAST][i] ^ pol[i]);
    end
  endgenerate

  assign raw = stg[LAST];

  // R3: an event needs the synchronized value to have just changed
  assert_evt_needs_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt & ~(raw ^ prev)) == '0);
endmodule

// File: rtl/irq_out_bank.sv
module irq_out_bank #(
  parameter int N_EXT = 14,
  parameter int N_INT = 10,
  localparam int N_SRC = N_EXT + N_INT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EXT-1:0] trig,
  input  logic [N_EXT-1:0] evt,
  input  logic [N_EXT-1:0] lvl,
  input  logic [N_INT-1:0] int_req,
  input  logic [N_SRC-1:0] clr,
  input  logic             mask_wr,
  input  logic [N_SRC-1:0] mask_wdata,
  output logic [N_SRC-1:0] mask,
  output logic [N_SRC-1:0] status,
  output logic             irq
);
  logic [N_EXT-1:0] ext_pend;
  logic [N_INT-1:0] int_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_pend <= '0;
      int_pend <= '0;
      mask     <= '0;
    end else begin
      // level-mode lines keep no stored bit; new events win over a clear
      ext_pend <= trig & ((ext_pend & ~clr[N_EXT-1:0]) | evt);
      int_pend <= (int_pend & ~clr[N_SRC-1:N_EXT]) | int_req;
      if (mask_wr) mask <= mask_wdata;
    end
  end

  assign status = {int_pend, (trig & ext_pend) | (~trig & lvl)};
  assign irq    = |(status & mask);

  // R4: an edge-mode pending bit survives until a clear
  assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ext_pend & ~clr[N_EXT-1:0] & trig) & trig & ~ext_pend) == '0);
  // R3: a qualified edge event latches pending
  assert_evt_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(evt & trig) & trig & ~ext_pend) == '0);
  // R6: an internal request is visible in status the next cycle
  assert_int_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(int_req) & ~status[N_SRC-1:N_EXT]) == '0);
  // R7: the output never rises without an enabled source
  assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask != '0));
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_pkg::*;
#(
  parameter int N_EXT = 14,
  parameter int N_INT = 10,
  parameter int N_OUT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_irq_in,
  input  logic [N_INT-1:0]  int_req,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_OUT-1:0]  irq_out
);
  localparam int N_SRC = N_EXT + N_INT;

  logic [N_EXT-1:0] pol_q, trig_q, raw, evt, lvl;
  logic [N_SRC-1:0] mask_v [N_OUT];
  logic [N_SRC-1:0] stat_v [N_OUT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      trig_q <= '0;
    end else if (reg_wr) begin
      if (reg_addr == ADR_POL)  pol_q  <= reg_wdata[N_EXT-1:0];
      if (reg_addr == ADR_TRIG) trig_q <= reg_wdata[N_EXT-1:0];
    end
  end

  irq_line_cond #(.N_LINES(N_EXT), .SYNC_STAGES(2)) u_cond (
    .clk(clk), .rst_n(rst_n), .pin_in(ext_irq_in), .pol(pol_q),
    .raw(raw), .evt(evt), .lvl(lvl)
  );

  genvar k;
  generate
    for (k = 0; k < N_OUT; k++) begin : g_out
      logic             sel_mask, sel_stat;
      logic [N_SRC-1:0] clr;
      assign sel_mask = reg_wr && (reg_addr == ADDR_W'(MASK_BASE + k));
      assign sel_stat = reg_wr && (reg_addr == ADDR_W'(STAT_BASE + k));
      assign clr      = sel_stat ? reg_wdata[N_SRC-1:0] : '0;

      irq_out_bank #(.N_EXT(N_EXT), .N_INT(N_INT)) u_bank (
        .clk(clk), .rst_n(rst_n), .trig(trig_q), .evt(evt), .lvl(lvl),
        .int_req(int_req), .clr(clr), .mask_wr(sel_mask),
        .mask_wdata(reg_wdata[N_SRC-1:0]), .mask(mask_v[k]),
        .status(stat_v[k]), .irq(irq_out[k])
      );
    end
  endgenerate

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADR_POL:  reg_rdata[N_EXT-1:0] = pol_q;
      ADR_TRIG: reg_rdata[N_EXT-1:0] = trig_q;
      ADR_RAW:  reg_rdata[N_EXT-1:0] = raw;
      default: begin
        for (int j = 0; j < N_OUT; j++) begin
          if (reg_addr == ADDR_W'(MASK_BASE + j)) reg_rdata[N_SRC-1:0] = mask_v[j];
          if (reg_addr == ADDR_W'(STAT_BASE + j)) reg_rdata[N_SRC-1:0] = stat_v[j];
        end
      end
    endcase
  end

  // R10: the hole at address 3 always reads zero
  assert_hole_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(3)) |-> (reg_rdata == '0));
  // R10: bits above the source field never read back set
  assert_upper_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:N_SRC] == '0);
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ext_irq_in = '1;
  logic [9:0]  int_req = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [2:0]  irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .ext_irq_in(ext_irq_in), .int_req(int_req),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  // {pol, trig, pin_before, pin_after, expected_status}
  localparam logic [4:0] VEC [8] = '{
    5'b1_1_0_1_1, 5'b1_1_1_0_0, 5'b0_1_1_0_1, 5'b0_1_0_1_0,
    5'b1_0_0_1_1, 5'b1_0_1_0_0, 5'b0_0_1_0_1, 5'b0_0_0_1_0
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    rd(4'd0, d); check("R1 pol", d, 0);
    rd(4'd1, d); check("R1 trig", d, 0);
    rd(4'd4, d); check("R1 mask0", d, 0);
    rd(4'd8, d); check("R1 status0", d, 0);
    check("R1 irq", {29'd0, irq_out}, 0);

    // R2/R3 vector walk
    for (int r = 0; r < 8; r++) begin
      int ln;
      ln = 13 - r;
      wr(4'd0, {31'd0, VEC[r][4]} << ln);
      wr(4'd1, {31'd0, VEC[r][3]} << ln);
      wr(4'd4, 32'd1 << ln);
      ext_irq_in[ln] = VEC[r][2];
      idle(5);
      wr(4'd8, 32'hFFFF_FFFF);
      ext_irq_in[ln] = VEC[r][1];
      idle(5);
      rd(4'd8, d);
      check(VEC[r][3] ? "R3 edge status" : "R2 level status", {31'd0, d[ln]}, {31'd0, VEC[r][0]});
      check("R7 irq0 follows", {31'd0, irq_out[0]}, {31'd0, VEC[r][0]});
      ext_irq_in[ln] = 1'b1;
      idle(5);
    end
    wr(4'd4, 0); wr(4'd0, 0); wr(4'd1, 0); wr(4'd8, 32'hFFFF_FFFF);

    // R3 synchronizer latency, falling edge on line 5
    wr(4'd1, 32'h20);
    wr(4'd8, 32'hFFFF_FFFF);
    reg_addr = 4'd8;
    @(negedge clk); ext_irq_in[5] = 1'b0;
    @(negedge clk); @(negedge clk);
    #1 check("R3 not yet after two edges", {31'd0, reg_rdata[5]}, 0);
    @(negedge clk);
    #1 check("R3 pending after third edge", {31'd0, reg_rdata[5]}, 1);
    ext_irq_in[5] = 1'b1;
    idle(4);
    rd(4'd8, d); check("R3 sticky after pin returns", {31'd0, d[5]}, 1);
    // R8 unmasked status visible
    rd(4'd4, d); check("R8 mask0 is zero", d, 0);
    rd(4'd8, d); check("R8 status despite mask", {31'd0, d[5]}, 1);
    // R4 write-0 keeps, write-1 clears
    wr(4'd8, 32'h0000_0010);
    rd(4'd8, d); check("R4 other bit clear keeps", {31'd0, d[5]}, 1);
    wr(4'd8, 32'h0000_0020);
    rd(4'd8, d); check("R4 clear", {31'd0, d[5]}, 0);
    wr(4'd1, 0);

    // R5 level clear has no effect while active (line 3 active-low)
    ext_irq_in[3] = 1'b0;
    idle(4);
    wr(4'd8, 32'h8);
    rd(4'd8, d); check("R5 level survives clear", {31'd0, d[3]}, 1);
    ext_irq_in[3] = 1'b1;
    idle(4);
    rd(4'd8, d); check("R5 level drops with pin", {31'd0, d[3]}, 0);

    // R6 internal request sticky, set wins over clear
    @(negedge clk); int_req[6] = 1'b1;
    @(negedge clk); int_req[6] = 1'b0;
    idle(2);
    rd(4'd9, d); check("R6 watchdog bit 20 sticky", {31'd0, d[20]}, 1);
    @(negedge clk); int_req[0] = 1'b1;
    wr(4'd8, 32'h0000_4000);
    rd(4'd8, d); check("R6 set wins over clear", {31'd0, d[14]}, 1);
    @(negedge clk); int_req[0] = 1'b0;
    wr(4'd8, 32'h0000_4000);
    rd(4'd8, d); check("R6 cleared after release", {31'd0, d[14]}, 0);

    // R7 independent outputs: bit 20 pending in copies 1 and 2
    wr(4'd5, 32'h0010_0000);
    idle(1);
    check("R7 irq1 high irq0 low", {29'd0, irq_out}, 32'd2);
    wr(4'd9, 32'h0010_0000);
    idle(1);
    check("R7 irq1 low after own clear", {29'd0, irq_out}, 0);
    rd(4'd10, d); check("R7 copy2 untouched", {31'd0, d[20]}, 1);
    wr(4'd8, 32'hFFFF_FFFF); wr(4'd10, 32'hFFFF_FFFF); wr(4'd5, 0);

    // R9 raw pins
    ext_irq_in = 14'h2A5C;
    idle(4);
    rd(4'd2, d); check("R9 raw pins", d, 32'h2A5C);
    ext_irq_in = '1;
    idle(4);

    // R10 unused address and upper bits
    wr(4'd0, 32'hFFFF_FFFF);
    rd(4'd0, d); check("R10 pol upper bits zero", d, 32'h3FFF);
    wr(4'd0, 0);
    rd(4'd3, d); check("R10 hole reads zero", d, 0);
    wr(4'd6, 32'hFFFF_FFFF);
    rd(4'd6, d); check("R10 mask width", d, 32'h00FF_FFFF);
    wr(4'd6, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule